// File: doc/BRIEF.md
# Two-Round SHA-256 Compression Core

This block runs the SHA-256 compression function over one padded 512-bit message block and applies two rounds in every clock cycle. The 64 message schedule words come from a separate scheduler, two per cycle. The core tells the scheduler which pair it needs through a pair index. Each cycle, the second round is built on the new `a` and `e` that the first round produces inside the same cycle, so all 64 rounds take 32 cycles. One more cycle adds the working variables into the chaining values.

A single-cycle `start` begins a hash. The working variables and the chaining values both load the standard SHA-256 initial values. The core then steps through pairs 0 to 31. It reads the two round constants for each pair from an internal table, and it reads schedule words W(2k) and W(2k+1) from `round_words`. After the final addition, the 256-bit digest is ready and `digest_valid` pulses for one cycle. The digest then holds until the next accepted start.

Top module: `sha2x_core`

## Requirements
- R1: After reset, `busy` and `digest_valid` are 0 and `pair_idx` is 0. `digest` shows the initial chaining values 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab and 5be0cd19, with the first one in bits 255:224.
- R2: A `start` sampled high while the core is idle is accepted. `busy` is then high for exactly 33 cycles, beginning in the cycle after the sampling edge: 32 round cycles and one final-addition cycle.
- R3: In round cycle k (k = 0..31), `pair_idx` equals k. The core takes `round_words[31:0]` as W(2k) and `round_words[63:32]` as W(2k+1), and it pairs them with round constants K(2k) and K(2k+1) from its own 64-entry table.
- R4: Each round cycle applies two SHA-256 rounds in sequence. The second round uses the old `g` as its `h`, Σ1 and Ch over (new e, e, f), Σ0 and Maj over (new a, a, b), and K and W of the odd round. The result equals 64 sequential rounds over the supplied words.
- R5: `digest` is H0..H7 concatenated, with H0 in bits 255:224. Each Hi is the initial value plus the matching final working variable, modulo 2^32. The empty-message block yields e3b0c442...7852b855.
- R6: `digest_valid` is high for exactly one cycle. That cycle follows the 33rd rising edge after the edge that accepted `start`, and `busy` is low in it.
- R7: A `start` that arrives while `busy` is high is ignored. The pair sequence, the pulse timing and the digest are the same as without it.
- R8: `digest` changes only at an accepted start, which reloads the initial values, and at the final-addition edge. It stays stable at all other times.
- R9: A `start` given in the `digest_valid` cycle is accepted, so hashes can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin hashing one block (taken only when idle) |
| round_words | input | 64 | Schedule words for the current pair: W(2k) in bits 31:0, W(2k+1) in bits 63:32 |
| pair_idx | output | 5 | Index k of the round pair being computed |
| busy | output | 1 | Hash in progress (round or final-addition cycle) |
| digest | output | 256 | H0..H7, with H0 in the most significant word |
| digest_valid | output | 1 | One-cycle pulse when the digest is final |

## Verification
When `start` is accepted at an edge, `busy` and `pair_idx` = 0 are due after that same edge. `pair_idx` then advances by one per edge. `busy` falls and `digest_valid` rises after the 33rd edge, which is also when the new digest appears. The bench's behavioural model advances its own phase counter on every rising edge, using the same `start` the core sees. It compares `busy`, `pair_idx`, `digest_valid` and `digest` at every falling edge, so each result is checked in the cycle it is due. Separate directed checks count the falling edges from the start request to the pulse. They expect 34, which is one edge to accept `start` plus 33. They also compare the finished digests against known SHA-256 values and against sequential single-round computation.

// File: rtl/sha2x_pkg.sv
package sha2x_pkg;

  localparam int WORD_W = 32;
  localparam int ROUNDS = 64;
  localparam int NVARS  = 8;

  typedef logic [WORD_W-1:0] word_t;

  // Working state; field a sits in the top word so the packed value
  // doubles as the digest ordering (first chaining word most significant).
  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } work_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sigma0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sigma1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  // One compression round applied to a full working state.
  function automatic work_t round_step(input work_t s, input word_t k, input word_t w);
    word_t t1;
    word_t t2;
    work_t n;
    t1  = s.h + big_sigma1(s.e) + choose(s.e, s.f, s.g) + k + w;
    t2  = big_sigma0(s.a) + majority(s.a, s.b, s.c);
    n.a = t1 + t2;
    n.b = s.a;
    n.c = s.b;
    n.d = s.c;
    n.e = s.d + t1;
    n.f = s.e;
    n.g = s.f;
    n.h = s.g;
    return n;
  endfunction

  // Word-wise modular sum of two states (the final chaining update).
  function automatic work_t fold_add(input work_t x, input work_t y);
    work_t r;
    r.a = x.a + y.a;
    r.b = x.b + y.b;
    r.c = x.c + y.c;
    r.d = x.d + y.d;
    r.e = x.e + y.e;
    r.f = x.f + y.f;
    r.g = x.g + y.g;
    r.h = x.h + y.h;
    return r;
  endfunction

  function automatic work_t init_chain();
    work_t v;
    v.a = 32'h6a09e667;
    v.b = 32'hbb67ae85;
    v.c = 32'h3c6ef372;
    v.d = 32'ha54ff53a;
    v.e = 32'h510e527f;
    v.f = 32'h9b05688c;
    v.g = 32'h1f83d9ab;
    v.h = 32'h5be0cd19;
    return v;
  endfunction

endpackage

// File: rtl/sha2x_kconst.sv
module sha2x_kconst
  import sha2x_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int PIDX_W = 5
) (
  input  logic [PIDX_W-1:0]       pair_idx,
  output logic [LANES*WORD_W-1:0] k_lanes
);

  localparam int KIDX_W = $clog2(ROUNDS);

  localparam word_t KTAB [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  // Lane l of pair k reads entry k*LANES + l.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [KIDX_W-1:0] kidx;
    assign kidx = KIDX_W'(int'(pair_idx) * LANES + l);
    assign k_lanes[l*WORD_W +: WORD_W] = KTAB[kidx];
  end

endmodule

// File: rtl/sha2x_round_chain.sv
module sha2x_round_chain
  import sha2x_pkg::*;
#(
  parameter int LANES = 2
) (
  input  work_t                   cur_state,
  input  logic [LANES*WORD_W-1:0] k_lanes,
  input  logic [LANES*WORD_W-1:0] w_lanes,
  output work_t                   nxt_state
);

  // stage[l] is the state entering lane l; each lane builds on the
  // new a and e of the previous lane within the same cycle.
  work_t stage [LANES+1];

  assign stage[0] = cur_state;

  for (genvar l = 0; l < LANES; l++) begin : g_round
    assign stage[l+1] = round_step(stage[l],
                                   k_lanes[l*WORD_W +: WORD_W],
                                   w_lanes[l*WORD_W +: WORD_W]);
  end

  assign nxt_state = stage[LANES];

endmodule

// File: rtl/sha2x_ctrl.sv
module sha2x_ctrl #(
  parameter int PAIRS  = 32,
  parameter int PIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              start_accept,
  output logic              rounds_active,
  output logic              final_add,
  output logic              busy,
  output logic              digest_valid,
  output logic [PIDX_W-1:0] pair_idx
);

  localparam logic [PIDX_W-1:0] LAST_PAIR = PIDX_W'(PAIRS - 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUND = 2'd1,
    ST_FOLD  = 2'd2
  } phase_e;

  phase_e            phase_q;
  logic [PIDX_W-1:0] cnt_q;
  logic              valid_q;

  assign start_accept  = start && (phase_q == ST_IDLE);
  assign rounds_active = (phase_q == ST_ROUND);
  assign final_add     = (phase_q == ST_FOLD);
  assign busy          = (phase_q != ST_IDLE);
  assign digest_valid  = valid_q;
  assign pair_idx      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (phase_q == ST_FOLD);
      unique case (phase_q)
        ST_IDLE: begin
          if (start) begin
            phase_q <= ST_ROUND;
            cnt_q   <= '0;
          end
        end
        ST_ROUND: begin
          if (cnt_q == LAST_PAIR) begin
            phase_q <= ST_FOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FOLD: phase_q <= ST_IDLE;
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sha2x_core.sv
module sha2x_core
  import sha2x_pkg::*;
#(
  parameter  int UNFOLD = 2,
  localparam int PAIRS  = ROUNDS / UNFOLD,
  localparam int PIDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [UNFOLD*WORD_W-1:0] round_words,
  output logic [PIDX_W-1:0]        pair_idx,
  output logic                     busy,
  output logic [NVARS*WORD_W-1:0]  digest,
  output logic                     digest_valid
);

  logic                     start_accept;
  logic                     rounds_active;
  logic                     final_add;
  logic [UNFOLD*WORD_W-1:0] k_lanes;
  work_t                    work_q;
  work_t                    chain_q;
  work_t                    work_nxt;

  sha2x_ctrl #(
    .PAIRS  (PAIRS),
    .PIDX_W (PIDX_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_accept  (start_accept),
    .rounds_active (rounds_active),
    .final_add     (final_add),
    .busy          (busy),
    .digest_valid  (digest_valid),
    .pair_idx      (pair_idx)
  );

  sha2x_kconst #(
    .LANES  (UNFOLD),
    .PIDX_W (PIDX_W)
  ) u_kconst (
    .pair_idx (pair_idx),
    .k_lanes  (k_lanes)
  );

  sha2x_round_chain #(
    .LANES (UNFOLD)
  ) u_chain (
    .cur_state (work_q),
    .k_lanes   (k_lanes),
    .w_lanes   (round_words),
    .nxt_state (work_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= init_chain();
      chain_q <= init_chain();
    end else if (start_accept) begin
      work_q  <= init_chain();
      chain_q <= init_chain();
    end else if (rounds_active) begin
      work_q  <= work_nxt;
    end else if (final_add) begin
      chain_q <= fold_add(chain_q, work_q);
    end
  end

  assign digest = chain_q;

endmodule

// File: rtl/sha2x_core_chk.sv
module sha2x_core_chk #(
  parameter int CW   = 5,
  parameter int LAST = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          digest_valid,
  input logic [CW-1:0] pair_idx,
  input logic [255:0]  digest,
  input logic          start_accept,
  input logic          rounds_active,
  input logic          final_add
);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> rounds_active && pair_idx == '0); // R2

  AST_LAST_TO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rounds_active && pair_idx == CW'(LAST) |=> final_add && busy); // R2

  AST_PAIR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rounds_active && pair_idx != CW'(LAST) |=> rounds_active && pair_idx == CW'($past(pair_idx) + 1'b1)); // R3

  AST_FOLD_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    final_add |=> digest_valid && !busy); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid |=> !digest_valid); // R6

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> !(rounds_active && pair_idx == '0)); // R7

  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_accept && !final_add |=> $stable(digest)); // R8

  AST_PULSE_ACCEPTS_START: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid && start |=> rounds_active && pair_idx == '0); // R9

endmodule

bind sha2x_core sha2x_core_chk #(
  .CW   (PIDX_W),
  .LAST (PAIRS - 1)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .digest_valid  (digest_valid),
  .pair_idx      (pair_idx),
  .digest        (digest),
  .start_accept  (start_accept),
  .rounds_active (rounds_active),
  .final_add     (final_add)
);

// File: tb/test_sha2x_core.sv
`timescale 1ns/1ps
module test_sha2x_core;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  round_words;
  logic [4:0]   pair_idx;
  logic         busy;
  logic [255:0] digest;
  logic         digest_valid;

  logic [31:0]  sched [64];
  logic [31:0]  kb [64];
  logic [31:0]  ivb [8];
  logic [255:0] iv_cat;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign round_words = {sched[2*int'(pair_idx)+1], sched[2*int'(pair_idx)]};

  sha2x_core i_sha2x_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .round_words  (round_words),
    .pair_idx     (pair_idx),
    .busy         (busy),
    .digest       (digest),
    .digest_valid (digest_valid)
  );

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] dbl;
    dbl = {x, x} >> n;
    return dbl[31:0];
  endfunction

  function automatic logic [31:0] frac_root(input int p, input int deg);
    logic [127:0] tgt, lo, hi, mid, pw;
    tgt = (deg == 2) ? (128'(p) << 64) : (128'(p) << 96);
    lo = 0;
    hi = 128'(1) << 40;
    while (hi - lo > 1) begin
      mid = (lo + hi) >> 1;
      pw  = (deg == 2) ? mid * mid : mid * mid * mid;
      if (pw <= tgt) lo = mid; else hi = mid;
    end
    return lo[31:0];
  endfunction

  function automatic bit is_prime(input int n);
    for (int d = 2; d * d <= n; d++) if (n % d == 0) return 0;
    return 1;
  endfunction

  // 64 rounds, one at a time, over the bench arrays.
  function automatic logic [255:0] ref_compress();
    logic [31:0] v [8];
    logic [31:0] t1, t2, s1, s0, chv, mjv;
    for (int i = 0; i < 8; i++) v[i] = ivb[i];
    for (int t = 0; t < 64; t++) begin
      s1  = rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25);
      chv = (v[4] & v[5]) | (~v[4] & v[6]);
      t1  = v[7] + s1 + chv + kb[t] + sched[t];
      s0  = rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22);
      mjv = (v[0] & v[1]) | (v[2] & (v[0] | v[1]));
      t2  = s0 + mjv;
      for (int j = 7; j > 0; j--) v[j] = v[j-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    return {v[0]+ivb[0], v[1]+ivb[1], v[2]+ivb[2], v[3]+ivb[3],
            v[4]+ivb[4], v[5]+ivb[5], v[6]+ivb[6], v[7]+ivb[7]};
  endfunction

  task automatic load_block(input logic [31:0] blk [16]);
    logic [31:0] a0, a1;
    for (int t = 0; t < 16; t++) sched[t] = blk[t];
    for (int t = 16; t < 64; t++) begin
      a0 = rr(sched[t-15], 7) ^ rr(sched[t-15], 18) ^ (sched[t-15] >> 3);
      a1 = rr(sched[t-2], 17) ^ rr(sched[t-2], 19) ^ (sched[t-2] >> 10);
      sched[t] = a1 + sched[t-7] + a0 + sched[t-16];
    end
  endtask

  // Caller stands at a falling edge. Returns falling edges until the pulse.
  task automatic launch(input int poke_at, output int lat);
    start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      start = (poke_at != 0 && lat == poke_at);
    end while (!digest_valid && lat < 200);
    start = 1'b0;
  endtask

  // ---------------- cycle model ----------------
  int           m_phase = -1;
  logic [255:0] m_dig;
  logic [255:0] m_pend;
  bit           m_ready = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase <= -1;
      m_dig   <= iv_cat;
      m_ready <= 1'b1;
    end else if ((m_phase == -1 || m_phase == 33) && start) begin
      m_phase <= 0;
      m_dig   <= iv_cat;
      m_pend  <= ref_compress();
    end else if (m_phase >= 0 && m_phase <= 32) begin
      m_phase <= m_phase + 1;
      if (m_phase == 32) m_dig <= m_pend;
    end else begin
      m_phase <= -1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_ready && !finished) begin
      chk("R2", "busy", 256'(busy), 256'(m_phase >= 0 && m_phase <= 32));
      chk("R3", "pair_idx", 256'(pair_idx),
          256'((m_phase >= 0 && m_phase <= 31) ? m_phase : 0));
      chk("R6", "digest_valid", 256'(digest_valid), 256'(m_phase == 33));
      chk("R8", "digest per cycle", digest, m_dig);
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0]  blk [16];
    logic [255:0] held;
    int lat;
    int p;

    p = 2;
    for (int i = 0; i < 64; i++) begin
      while (!is_prime(p)) p++;
      kb[i] = frac_root(p, 3);
      if (i < 8) ivb[i] = frac_root(p, 2);
      p++;
    end
    iv_cat = {ivb[0], ivb[1], ivb[2], ivb[3], ivb[4], ivb[5], ivb[6], ivb[7]};
    for (int t = 0; t < 64; t++) sched[t] = '0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy after reset", 256'(busy), 256'(0));
    chk("R1", "valid after reset", 256'(digest_valid), 256'(0));
    chk("R1", "pair_idx after reset", 256'(pair_idx), 256'(0));
    chk("R1", "digest after reset", digest, iv_cat);

    // R4/R5: empty-message block
    for (int t = 0; t < 16; t++) blk[t] = '0;
    blk[0] = 32'h80000000;
    load_block(blk);
    launch(0, lat);
    chk("R6", "latency empty", 256'(lat - 1), 256'(33));
    chk("R5", "empty digest", digest,
        256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855);
    chk("R5", "H0 in top word", 256'(digest[255:224]), 256'(32'he3b0c442));
    chk("R4", "empty vs sequential", digest, ref_compress());

    // R8: digest held while idle
    held = digest;
    repeat (7) @(negedge clk);
    chk("R8", "digest held idle", digest, held);

    // R4: "abc" block
    for (int t = 0; t < 16; t++) blk[t] = '0;
    blk[0]  = 32'h61626380;
    blk[15] = 32'h00000018;
    load_block(blk);
    @(negedge clk);
    launch(0, lat);
    chk("R4", "abc digest", digest,
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

    // R3/R4: arbitrary words in every slot (lane order matters)
    for (int t = 0; t < 64; t++) sched[t] = $urandom();
    @(negedge clk);
    launch(0, lat);
    chk("R3", "random schedule digest", digest, ref_compress());

    // R7: start pokes while busy (mid-run, last pair, final-add cycle)
    for (int t = 0; t < 64; t++) sched[t] = $urandom();
    @(negedge clk);
    launch(10, lat);
    chk("R7", "latency with mid poke", 256'(lat - 1), 256'(33));
    chk("R7", "digest with mid poke", digest, ref_compress());
    @(negedge clk);
    launch(32, lat);
    chk("R7", "latency with late poke", 256'(lat - 1), 256'(33));
    @(negedge clk);
    launch(33, lat);
    chk("R7", "latency with fold poke", 256'(lat - 1), 256'(33));
    chk("R7", "digest with fold poke", digest, ref_compress());

    // R9: back-to-back start in the pulse cycle
    held = ref_compress();
    launch(0, lat);
    chk("R9", "back-to-back latency", 256'(lat - 1), 256'(33));
    chk("R9", "back-to-back digest", digest, held);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule